// File: doc/BRIEF.md
# Branch and Indexed Address Generator

This block is a purely combinational target calculator for a small controller with a 16-bit program counter. Each cycle the fetch stage presents the address of the instruction that follows the current one, a class code for the current instruction, and its operand fields. The block returns the program or code-memory address that the instruction selects, and a flag saying whether control flow leaves the sequential path.

Five kinds of target are formed. The first is a PC-relative branch with a signed byte offset. The second is a jump inside the current 2K page, which keeps the top five PC bits and replaces the low eleven. The third is a jump to a full 16-bit address. The last two are sums of the accumulator with either the data pointer or the PC, used for table reads and for a computed jump. Two fused conditional branches are also resolved here. Decrement-and-branch returns the decremented counter and branches while it is nonzero. Compare-and-branch branches when two bytes differ and reports an unsigned less-than flag. Every sum wraps modulo 2^16, and the accumulator is always zero-extended when it is used as an index.

Top module: `branch_addr_gen`

## Requirements
- R1: Class 0 (sequential) gives tgt_addr = pc_next and taken = 0.
- R2: Class 1 (relative branch) gives tgt_addr = pc_next + sign-extended rel_off, modulo 2^16, and taken = 1.
- R3: Class 2 (page jump) gives tgt_addr = {pc_next[15:11], abs_field[10:0]} and taken = 1.
- R4: Class 3 (long jump) gives tgt_addr = long_field and taken = 1.
- R5: Class 4 (table read via data pointer) gives tgt_addr = dptr + zero-extended acc, modulo 2^16, and taken = 0.
- R6: Class 5 (table read via PC) gives tgt_addr = pc_next + zero-extended acc, modulo 2^16, and taken = 0.
- R7: Class 6 (computed jump) gives tgt_addr = dptr + zero-extended acc, modulo 2^16, and taken = 1 always.
- R8: cnt_dec is always cnt_in - 1 modulo 256. For class 7 (decrement-and-branch), taken = 1 exactly when cnt_dec is nonzero. tgt_addr is then the relative target of R2, and otherwise it is pc_next. An input of 1 therefore falls through, and an input of 0 wraps to 255 and branches.
- R9: For class 8 (compare-and-branch), taken = 1 exactly when cmp_dst != cmp_src. tgt_addr is then the relative target of R2, and otherwise it is pc_next. In the same class, cmp_lt = 1 exactly when cmp_dst < cmp_src unsigned.
- R10: cmp_lt is 0 in every class other than 8.
- R11: Class codes 9 to 15 are reserved and behave as sequential: tgt_addr = pc_next and taken = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_next | input | 16 | Address of the following instruction |
| op_class | input | 4 | Instruction class code |
| rel_off | input | 8 | Signed relative offset |
| abs_field | input | 11 | In-page target field |
| long_field | input | 16 | Full target address |
| acc | input | 8 | Accumulator, used as index |
| dptr | input | 16 | Data pointer, used as base |
| cnt_in | input | 8 | Loop counter before decrement |
| cmp_dst | input | 8 | Compare left operand |
| cmp_src | input | 8 | Compare right operand |
| tgt_addr | output | 16 | Effective program or code address |
| taken | output | 1 | Control flow leaves the sequential path |
| cnt_dec | output | 8 | Decremented loop counter |
| cmp_lt | output | 1 | Unsigned less-than result of the compare |

## Verification
Random vectors spread over all sixteen class codes with full-range operands. They separate the target sources from one another, because each class draws on a different mix of pc_next, the fields, acc and dptr. Directed cases sit at the edges. Relative offsets of +127 and -128 near both ends of the address space check wrap and sign extension. A page jump at the top of a page shows that the PC's upper bits survive. Table reads that cross 0xFFFF check carry wrap and zero extension of acc. Counter inputs of 1 and 0 mark the branch/fall-through boundary, and equal, lower and higher compare operands separate taken from carry.

// File: rtl/bag_pkg.sv
package bag_pkg;
  localparam int unsigned CLS_W = 4;

  typedef enum logic [CLS_W-1:0] {
    CLS_SEQ     = 4'd0,
    CLS_REL     = 4'd1,
    CLS_PAGE    = 4'd2,
    CLS_LONG    = 4'd3,
    CLS_TBL_DP  = 4'd4,
    CLS_TBL_PC  = 4'd5,
    CLS_JMP_IDX = 4'd6,
    CLS_DEC_BR  = 4'd7,
    CLS_CMP_BR  = 4'd8
  } op_class_e;

  typedef enum logic [2:0] {
    SRC_PC   = 3'd0,
    SRC_REL  = 3'd1,
    SRC_PAGE = 3'd2,
    SRC_LONG = 3'd3,
    SRC_IDX  = 3'd4
  } tgt_src_e;
endpackage

// File: rtl/bag_rel_adder.sv
module bag_rel_adder #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 8
) (
  input  logic [PC_W-1:0]  base_pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  target
);
  localparam int unsigned EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;

  generate
    if (EXT_W > 0) begin : g_sext
      assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_trunc
      assign off_ext = offset[PC_W-1:0];
    end
  endgenerate

  assign target = base_pc + off_ext;
endmodule

// File: rtl/bag_index_adder.sv
module bag_index_adder #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned ACC_W = 8
) (
  input  logic             use_pc,
  input  logic [PC_W-1:0]  pc_base,
  input  logic [PC_W-1:0]  dp_base,
  input  logic [ACC_W-1:0] index,
  output logic [PC_W-1:0]  target
);
  localparam int unsigned PAD_W = PC_W - ACC_W;

  logic [PC_W-1:0] base;
  logic [PC_W-1:0] idx_ext;

  assign base = use_pc ? pc_base : dp_base;

  generate
    if (PAD_W > 0) begin : g_zext
      assign idx_ext = {{PAD_W{1'b0}}, index};
    end else begin : g_trunc
      assign idx_ext = index[PC_W-1:0];
    end
  endgenerate

  assign target = base + idx_ext;
endmodule

// File: rtl/bag_cond_unit.sv
module bag_cond_unit #(
  parameter int unsigned DAT_W = 8
) (
  input  logic             is_dec,
  input  logic             is_cmp,
  input  logic [DAT_W-1:0] cnt_in,
  input  logic [DAT_W-1:0] lhs,
  input  logic [DAT_W-1:0] rhs,
  output logic [DAT_W-1:0] cnt_dec,
  output logic             cond_hit,
  output logic             lt_flag
);
  localparam logic [DAT_W-1:0] ONE = DAT_W'(1);

  logic dec_nz;
  logic ne;
  logic [DAT_W:0] diff;

  always_comb begin
    cnt_dec = cnt_in - ONE;
    dec_nz  = |cnt_dec;
    ne      = |(lhs ^ rhs);
    diff    = {1'b0, lhs} - {1'b0, rhs};
    cond_hit = (is_dec & dec_nz) | (is_cmp & ne);
    lt_flag  = is_cmp & diff[DAT_W];
  end
endmodule

// File: rtl/bag_target_mux.sv
module bag_target_mux #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned ABS_W = 11
) (
  input  bag_pkg::tgt_src_e sel,
  input  logic [PC_W-1:0]   pc_next,
  input  logic [PC_W-1:0]   rel_tgt,
  input  logic [ABS_W-1:0]  abs_field,
  input  logic [PC_W-1:0]   long_field,
  input  logic [PC_W-1:0]   idx_tgt,
  output logic [PC_W-1:0]   tgt_addr
);
  import bag_pkg::*;

  localparam int unsigned KEEP_W = PC_W - ABS_W;

  logic [PC_W-1:0] page_tgt;

  generate
    if (KEEP_W > 0) begin : g_page
      assign page_tgt = {pc_next[PC_W-1:ABS_W], abs_field};
    end else begin : g_full
      assign page_tgt = abs_field[PC_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SRC_REL:  tgt_addr = rel_tgt;
      SRC_PAGE: tgt_addr = page_tgt;
      SRC_LONG: tgt_addr = long_field;
      SRC_IDX:  tgt_addr = idx_tgt;
      default:  tgt_addr = pc_next;
    endcase
  end
endmodule

// File: rtl/branch_addr_gen.sv
module branch_addr_gen #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned ABS_W = 11,
  parameter int unsigned ACC_W = 8
) (
  input  logic [PC_W-1:0]          pc_next,
  input  logic [bag_pkg::CLS_W-1:0] op_class,
  input  logic [OFF_W-1:0]         rel_off,
  input  logic [ABS_W-1:0]         abs_field,
  input  logic [PC_W-1:0]          long_field,
  input  logic [ACC_W-1:0]         acc,
  input  logic [PC_W-1:0]          dptr,
  input  logic [ACC_W-1:0]         cnt_in,
  input  logic [ACC_W-1:0]         cmp_dst,
  input  logic [ACC_W-1:0]         cmp_src,
  output logic [PC_W-1:0]          tgt_addr,
  output logic                     taken,
  output logic [ACC_W-1:0]         cnt_dec,
  output logic                     cmp_lt
);
  import bag_pkg::*;

  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] idx_tgt;
  logic            is_dec;
  logic            is_cmp;
  logic            idx_use_pc;
  logic            cond_hit;
  tgt_src_e        sel;

  assign is_dec     = (op_class == CLS_DEC_BR);
  assign is_cmp     = (op_class == CLS_CMP_BR);
  assign idx_use_pc = (op_class == CLS_TBL_PC);

  bag_rel_adder #(.PC_W(PC_W), .OFF_W(OFF_W)) i_rel (
    .base_pc (pc_next),
    .offset  (rel_off),
    .target  (rel_tgt)
  );

  bag_index_adder #(.PC_W(PC_W), .ACC_W(ACC_W)) i_idx (
    .use_pc  (idx_use_pc),
    .pc_base (pc_next),
    .dp_base (dptr),
    .index   (acc),
    .target  (idx_tgt)
  );

  bag_cond_unit #(.DAT_W(ACC_W)) i_cond (
    .is_dec   (is_dec),
    .is_cmp   (is_cmp),
    .cnt_in   (cnt_in),
    .lhs      (cmp_dst),
    .rhs      (cmp_src),
    .cnt_dec  (cnt_dec),
    .cond_hit (cond_hit),
    .lt_flag  (cmp_lt)
  );

  // Class decode: source select and branch flag
  always_comb begin
    sel   = SRC_PC;
    taken = 1'b0;
    case (op_class)
      CLS_REL:     begin sel = SRC_REL;  taken = 1'b1; end
      CLS_PAGE:    begin sel = SRC_PAGE; taken = 1'b1; end
      CLS_LONG:    begin sel = SRC_LONG; taken = 1'b1; end
      CLS_TBL_DP,
      CLS_TBL_PC:  begin sel = SRC_IDX;  taken = 1'b0; end
      CLS_JMP_IDX: begin sel = SRC_IDX;  taken = 1'b1; end
      CLS_DEC_BR,
      CLS_CMP_BR:  begin
        sel   = cond_hit ? SRC_REL : SRC_PC;
        taken = cond_hit;
      end
      default:     begin sel = SRC_PC;   taken = 1'b0; end
    endcase
  end

  bag_target_mux #(.PC_W(PC_W), .ABS_W(ABS_W)) i_mux (
    .sel        (sel),
    .pc_next    (pc_next),
    .rel_tgt    (rel_tgt),
    .abs_field  (abs_field),
    .long_field (long_field),
    .idx_tgt    (idx_tgt),
    .tgt_addr   (tgt_addr)
  );
endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFF_W = 8,
  parameter int unsigned ABS_W = 11,
  parameter int unsigned ACC_W = 8
) (
  input logic [PC_W-1:0]  pc_next,
  input logic [3:0]       op_class,
  input logic [ABS_W-1:0] abs_field,
  input logic [PC_W-1:0]  long_field,
  input logic [ACC_W-1:0] cnt_in,
  input logic [ACC_W-1:0] cmp_dst,
  input logic [ACC_W-1:0] cmp_src,
  input logic [PC_W-1:0]  tgt_addr,
  input logic             taken,
  input logic [ACC_W-1:0] cnt_dec,
  input logic             cmp_lt
);
  always_comb begin
    if (!$isunknown({op_class, pc_next, tgt_addr, taken, cmp_lt})) begin
      // R1, R11: sequential and reserved codes never branch
      a_r1_seq_stay: assert ((op_class != 4'd0 && op_class < 4'd9) || (!taken && tgt_addr == pc_next))
        else $error("R1/R11 sequential violated");
      // R3
      a_r3_page_kept: assert (op_class != 4'd2 || (tgt_addr[PC_W-1:ABS_W] == pc_next[PC_W-1:ABS_W]
                                                && tgt_addr[ABS_W-1:0] == abs_field && taken))
        else $error("R3 page jump violated");
      // R4
      a_r4_long: assert (op_class != 4'd3 || (tgt_addr == long_field && taken))
        else $error("R4 long jump violated");
      // R5, R6: table reads are not branches
      a_r5_tbl_nobranch: assert (!(op_class == 4'd4 || op_class == 4'd5) || !taken)
        else $error("R5/R6 table read flagged taken");
      // R7
      a_r7_jmp_always: assert (op_class != 4'd6 || taken)
        else $error("R7 computed jump not taken");
      // R8
      a_r8_dec_fall: assert (op_class != 4'd7 || (taken == (cnt_in != 8'd1)))
        else $error("R8 decrement branch decision wrong");
      a_r8_dec_pc: assert (op_class != 4'd7 || taken || tgt_addr == pc_next)
        else $error("R8 fall-through address wrong");
      // R9
      a_r9_cmp_taken: assert (op_class != 4'd8 || (taken == (cmp_dst != cmp_src)))
        else $error("R9 compare branch decision wrong");
      a_r9_cmp_lt_eq: assert (!(op_class == 4'd8 && cmp_dst == cmp_src) || (!cmp_lt && tgt_addr == pc_next))
        else $error("R9 equal compare wrong");
      // R10
      a_r10_lt_only_cmp: assert (!cmp_lt || op_class == 4'd8)
        else $error("R10 cmp_lt outside compare class");
      a_r8_cnt_wrap: assert (cnt_in != 8'd0 || cnt_dec == 8'hFF)
        else $error("R8 counter wrap wrong");
    end
  end
endmodule

bind branch_addr_gen bag_checker #(
  .PC_W(PC_W), .OFF_W(OFF_W), .ABS_W(ABS_W), .ACC_W(ACC_W)
) i_bag_checker (
  .pc_next    (pc_next),
  .op_class   (op_class),
  .abs_field  (abs_field),
  .long_field (long_field),
  .cnt_in     (cnt_in),
  .cmp_dst    (cmp_dst),
  .cmp_src    (cmp_src),
  .tgt_addr   (tgt_addr),
  .taken      (taken),
  .cnt_dec    (cnt_dec),
  .cmp_lt     (cmp_lt)
);

// File: tb/test_branch_addr_gen.sv
module test_branch_addr_gen;
  logic        clk;
  logic [15:0] pc_next;
  logic [3:0]  op_class;
  logic [7:0]  rel_off;
  logic [10:0] abs_field;
  logic [15:0] long_field;
  logic [7:0]  acc;
  logic [15:0] dptr;
  logic [7:0]  cnt_in;
  logic [7:0]  cmp_dst;
  logic [7:0]  cmp_src;
  logic [15:0] tgt_addr;
  logic        taken;
  logic [7:0]  cnt_dec;
  logic        cmp_lt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  branch_addr_gen i_branch_addr_gen (
    .pc_next(pc_next), .op_class(op_class), .rel_off(rel_off),
    .abs_field(abs_field), .long_field(long_field), .acc(acc),
    .dptr(dptr), .cnt_in(cnt_in), .cmp_dst(cmp_dst), .cmp_src(cmp_src),
    .tgt_addr(tgt_addr), .taken(taken), .cnt_dec(cnt_dec), .cmp_lt(cmp_lt)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic string req_tag(input logic [3:0] c);
    case (c)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4: return "R5";
      4'd5: return "R6";
      4'd6: return "R7";
      4'd7: return "R8";
      4'd8: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [15:0] rel_of(input logic [15:0] pc, input logic [7:0] o);
    int s;
    s = int'(pc) + int'($signed(o));
    return s[15:0];
  endfunction

  function automatic logic exp_taken(input logic [3:0] c, input logic [7:0] cnt,
                                     input logic [7:0] d, input logic [7:0] s);
    case (c)
      4'd1, 4'd2, 4'd3, 4'd6: return 1'b1;
      4'd7: return cnt != 8'd1;
      4'd8: return d != s;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_addr(input logic [3:0] c, input logic [15:0] pc,
      input logic [7:0] o, input logic [10:0] ab, input logic [15:0] lg,
      input logic [7:0] a, input logic [15:0] dp, input logic tk);
    int s;
    case (c)
      4'd1: return rel_of(pc, o);
      4'd2: return {pc[15:11], ab};
      4'd3: return lg;
      4'd4, 4'd6: begin s = int'(dp) + int'(a); return s[15:0]; end
      4'd5: begin s = int'(pc) + int'(a); return s[15:0]; end
      4'd7, 4'd8: return tk ? rel_of(pc, o) : pc;
      default: return pc;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [15:0] pc, input logic [7:0] o,
      input logic [10:0] ab, input logic [15:0] lg, input logic [7:0] a,
      input logic [15:0] dp, input logic [7:0] cnt, input logic [7:0] d, input logic [7:0] s);
    logic tk;
    @(posedge clk);
    #1;
    op_class = c; pc_next = pc; rel_off = o; abs_field = ab; long_field = lg;
    acc = a; dptr = dp; cnt_in = cnt; cmp_dst = d; cmp_src = s;
    @(negedge clk);
    tk = exp_taken(c, cnt, d, s);
    chk(req_tag(c), "taken", {15'd0, taken}, {15'd0, tk});
    chk(req_tag(c), "tgt_addr", tgt_addr, exp_addr(c, pc, o, ab, lg, a, dp, tk));
    chk("R8", "cnt_dec", {8'd0, cnt_dec}, {8'd0, 8'(cnt - 8'd1)});
    chk((c == 4'd8) ? "R9" : "R10", "cmp_lt", {15'd0, cmp_lt},
        {15'd0, (c == 4'd8) && (d < s)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op_class = 0; pc_next = 0; rel_off = 0; abs_field = 0; long_field = 0;
    acc = 0; dptr = 0; cnt_in = 0; cmp_dst = 0; cmp_src = 0;
    void'($urandom(32'd20240611));
    // Initial quiet state, R1
    @(negedge clk);
    chk("R1", "idle taken", {15'd0, taken}, 16'd0);
    chk("R1", "idle addr", tgt_addr, 16'd0);
    // R2 wrap forward and backward
    apply(4'd1, 16'hFFF0, 8'h7F, 0, 0, 0, 0, 8'd5, 0, 0);
    apply(4'd1, 16'h0010, 8'h80, 0, 0, 0, 0, 8'd5, 0, 0);
    // R3 top of page, upper bits kept
    apply(4'd2, 16'hF7FE, 0, 11'h7FF, 0, 0, 0, 8'd5, 0, 0);
    apply(4'd2, 16'h0800, 0, 11'h000, 0, 0, 0, 8'd5, 0, 0);
    // R4
    apply(4'd3, 16'h1234, 0, 0, 16'hBEEF, 0, 0, 8'd5, 0, 0);
    // R5, R6, R7 carry wrap and zero extension
    apply(4'd4, 16'h0100, 0, 0, 0, 8'h02, 16'hFFFF, 8'd5, 0, 0);
    apply(4'd5, 16'hFF80, 0, 0, 0, 8'hFF, 16'h0000, 8'd5, 0, 0);
    apply(4'd6, 16'h0100, 0, 0, 0, 8'h80, 16'h3000, 8'd5, 0, 0);
    // R8 boundary counters
    apply(4'd7, 16'h4000, 8'hF0, 0, 0, 0, 0, 8'd1, 0, 0);
    apply(4'd7, 16'h4000, 8'hF0, 0, 0, 0, 0, 8'd0, 0, 0);
    apply(4'd7, 16'h4000, 8'h10, 0, 0, 0, 0, 8'd2, 0, 0);
    // R9 equal, lower, higher
    apply(4'd8, 16'h5000, 8'h20, 0, 0, 0, 0, 8'd5, 8'h60, 8'h60);
    apply(4'd8, 16'h5000, 8'h20, 0, 0, 0, 0, 8'd5, 8'h5F, 8'h60);
    apply(4'd8, 16'h5000, 8'h20, 0, 0, 0, 0, 8'd5, 8'h61, 8'h60);
    // R10 no carry outside compare; R11 reserved
    apply(4'd1, 16'h5000, 8'h20, 0, 0, 0, 0, 8'd5, 8'h00, 8'hFF);
    apply(4'd15, 16'h6000, 8'h20, 11'h123, 16'h9999, 8'h11, 16'h2222, 8'd5, 8'h00, 8'hFF);
    apply(4'd9, 16'h6000, 8'h20, 11'h123, 16'h9999, 8'h11, 16'h2222, 8'd5, 8'h00, 8'hFF);
    // Random mix over all codes
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d, s;
      d = 8'($urandom);
      s = ($urandom % 4 == 0) ? d : 8'($urandom);
      apply(4'($urandom), 16'($urandom), 8'($urandom), 11'($urandom), 16'($urandom),
            8'($urandom), 16'($urandom), 8'($urandom % 4 == 0 ? 1 : $urandom), d, s);
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule